// File: doc/BRIEF.md
# Frame Descriptor Chain Fetcher

The block feeds a display controller from memory by walking a linked list of descriptors. Every descriptor occupies four consecutive 32-bit words: a link to the next descriptor, the byte address of a payload buffer, an identifier for the frame, and a command word. The command word carries the payload length, counted in 32-bit words, and a flag that says whether the payload is colour-lookup data or pixel data. The fetcher reads a descriptor, then reads its payload in bursts of up to sixteen words and hands the words to one of two output streams. Only after the last payload item has been accepted downstream does it follow the link to the next descriptor.

Software writes the address of the first descriptor with a one-cycle strobe and holds the enable input high. A chain may loop forever. A frame descriptor can link to itself, for true-colour modes with no lookup table. A lookup descriptor and a frame descriptor can also link to each other, so that the table is reloaded before every frame. Dropping the enable lets the current payload complete and then parks the fetcher. A new start strobe is needed to run it again.

The memory side is a word-read port. A request carries a byte address and a word count and is held until accepted. Read data returns in order, one word per valid cycle, with no back-pressure. The fetcher only issues a burst when its internal buffer has room for every word it has asked for. Both output streams are valid/ready. Once an output raises valid, its data stays fixed until ready is seen high at a clock edge. A sink that stalls only delays the stream and never loses or reorders an item. A one-cycle frame-start pulse marks every pixel descriptor that is loaded.

Top module: `frame_chain_fetcher`

## Requirements
- R1: A descriptor fetch is a single 4-word read request at the descriptor's byte address. The returned words are taken in this order: link address, payload byte address, frame identifier, command.
- R2: The payload length is command bits [23:0], counted in 32-bit words. Payload words are read from ascending byte addresses starting at the payload address, 4 bytes per word.
- R3: A payload read request asks for at most 16 words. Every payload burst is exactly 16 words except the last, which carries the remainder. A request keeps its address and length stable until it is accepted.
- R4: When command bit 28 is 1, each payload word yields two 16-bit entries on the lookup stream, bits [15:0] first and bits [31:16] second. When bit 28 is 0, each payload word goes unchanged to the pixel stream. The two streams are never valid in the same cycle.
- R5: `frame_start` pulses for exactly one cycle each time a descriptor with command bit 28 equal to 0 is loaded, and `frame_id` then shows that descriptor's identifier. Descriptors with bit 28 set produce no pulse.
- R6: The next descriptor is requested only after every output item of the current payload has been accepted by its sink.
- R7: The fetcher follows link addresses indefinitely, including a descriptor that links to itself and two descriptors that link to each other.
- R8: With `enable` low, the current payload still completes, but no further descriptor is requested. The fetcher stays idle afterwards, even with `enable` high again, until a new start strobe.
- R9: A start strobe that arrives while the fetcher is active is ignored.
- R10: Each output stream holds its valid and data stable while stalled. Sink back-pressure never drops, duplicates or reorders items.
- R11: A descriptor with length 0 causes no payload read, and the fetcher goes straight on to the linked descriptor.
- R12: After reset, and before any start strobe, no read request is issued and no output is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run permission; sampled before each descriptor fetch |
| start_wr | input | 1 | One-cycle strobe that loads the first descriptor address (honoured only when idle) |
| start_addr | input | ADDR_W | Byte address of the first descriptor |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the first word of the request |
| mem_req_len | output | clog2(BURST+1) | Number of words requested |
| mem_rsp_valid | input | 1 | Read data word valid |
| mem_rsp_data | input | 32 | Read data word |
| pal_valid | output | 1 | Lookup entry valid |
| pal_ready | input | 1 | Lookup sink ready |
| pal_data | output | 16 | Lookup entry |
| pix_valid | output | 1 | Pixel word valid |
| pix_ready | input | 1 | Pixel sink ready |
| pix_data | output | 32 | Pixel word |
| frame_start | output | 1 | One-cycle pulse on loading a pixel descriptor |
| frame_id | output | 32 | Identifier of the most recently loaded descriptor |

## Verification
Two events can fall in the same cycle and have to be tested together. In the first, read data is written into the payload buffer while a sink pops from it. In the second, a new burst is granted while the buffer's free space is shrinking. Both are provoked by pseudo-random stalls on the request accept, on the read data and on both sink readies, using payloads longer than the buffer. The results are judged on the exact word order and count seen at each sink. A third coincidence is a lookup-to-frame handover with back-pressure still active on the lookup stream. It is judged by recording, for each descriptor request, how many output items had already been delivered, and requiring that number to equal the complete sum of the preceding payloads.

// File: rtl/fcf_pkg.sv
`timescale 1ns/1ps
package fcf_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;

  // order in which descriptor words return from memory
  localparam logic [1:0] W_LINK = 2'd0;
  localparam logic [1:0] W_SRC  = 2'd1;
  localparam logic [1:0] W_ID   = 2'd2;
  localparam logic [1:0] W_CMD  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRSP,
    ST_PAY
  } fcf_state_e;
endpackage

// File: rtl/fcf_word_fifo.sv
`timescale 1ns/1ps
module fcf_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign empty   = (count == '0);
  assign dout    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fcf_route.sv
`timescale 1ns/1ps
module fcf_route #(
  parameter int W  = 32,
  parameter int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  head,
  input  logic          head_vld,
  input  logic          pal_mode,
  output logic          pop,
  output logic          pal_valid,
  input  logic          pal_ready,
  output logic [HW-1:0] pal_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [W-1:0]  pix_data
);
  // upper-half pointer: set once the lower half of the head word is taken
  logic upper;

  assign pal_valid = head_vld && pal_mode;
  assign pix_valid = head_vld && !pal_mode;
  assign pal_data  = upper ? head[W-1:HW] : head[HW-1:0];
  assign pix_data  = head;
  assign pop       = pal_mode ? (pal_valid && pal_ready && upper)
                              : (pix_valid && pix_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     upper <= 1'b0;
    else if (pal_valid && pal_ready) upper <= !upper;
  end
endmodule

// File: rtl/fcf_ctrl.sv
`timescale 1ns/1ps
module fcf_ctrl
  import fcf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BURST   = 16,
  parameter int DEPTH   = 32,
  parameter int LEN_W   = 24,
  parameter int PAL_BIT = 28,
  parameter int CW      = $clog2(DEPTH) + 1,
  parameter int BL_W    = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BL_W-1:0]   mem_req_len,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              buf_push,
  input  logic [CW-1:0]     buf_count,
  input  logic              buf_empty,
  output logic              pal_mode,
  output logic              frame_start,
  output logic [WORD_W-1:0] frame_id
);
  localparam int SW = CW + 1;

  fcf_state_e        state;
  logic              armed;
  logic [ADDR_W-1:0] link_ptr;
  logic [ADDR_W-1:0] src_ptr;
  logic [LEN_W-1:0]  remain;
  logic [CW-1:0]     pending;
  logic [1:0]        widx;

  logic [BL_W-1:0]   blen;
  logic [SW-1:0]     space;
  logic              pay_req, pay_issue, pay_done, rsp_pay;

  always_comb begin
    blen      = (remain > LEN_W'(BURST)) ? BL_W'(BURST) : BL_W'(remain);
    space     = SW'(DEPTH) - SW'(buf_count) - SW'(pending);
    pay_req   = (state == ST_PAY) && (remain != '0) && (space >= SW'(blen));
    pay_issue = pay_req && mem_req_ready;
    rsp_pay   = mem_rsp_valid && (state == ST_PAY);
    pay_done  = (state == ST_PAY) && (remain == '0) && (pending == '0) && buf_empty;
    mem_req_valid = (state == ST_DREQ) || pay_req;
    mem_req_addr  = (state == ST_DREQ) ? link_ptr : src_ptr;
    mem_req_len   = (state == ST_DREQ) ? BL_W'(DESC_WORDS) : blen;
  end

  assign buf_push = rsp_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      armed       <= 1'b0;
      link_ptr    <= '0;
      src_ptr     <= '0;
      remain      <= '0;
      pending     <= '0;
      widx        <= '0;
      pal_mode    <= 1'b0;
      frame_start <= 1'b0;
      frame_id    <= '0;
    end else begin
      frame_start <= 1'b0;
      pending <= pending + (pay_issue ? CW'(blen) : CW'(0)) - (rsp_pay ? CW'(1) : CW'(0));
      case (state)
        ST_IDLE: begin
          if (start_wr) begin
            link_ptr <= start_addr;
            armed    <= 1'b1;
          end
          if (armed && enable) state <= ST_DREQ;
        end
        ST_DREQ: begin
          if (mem_req_ready) begin
            state <= ST_DRSP;
            widx  <= '0;
          end
        end
        ST_DRSP: begin
          if (mem_rsp_valid) begin
            widx <= widx + 1'b1;
            case (widx)
              W_LINK: link_ptr <= mem_rsp_data[ADDR_W-1:0];
              W_SRC:  src_ptr  <= mem_rsp_data[ADDR_W-1:0];
              W_ID:   frame_id <= mem_rsp_data;
              default: begin
                remain      <= mem_rsp_data[LEN_W-1:0];
                pal_mode    <= mem_rsp_data[PAL_BIT];
                frame_start <= !mem_rsp_data[PAL_BIT];
                state       <= ST_PAY;
              end
            endcase
          end
        end
        default: begin
          if (pay_issue) begin
            src_ptr <= src_ptr + ADDR_W'({blen, 2'b00});
            remain  <= remain - LEN_W'(blen);
          end
          if (pay_done) begin
            if (enable) begin
              state <= ST_DREQ;
            end else begin
              state <= ST_IDLE;
              armed <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/frame_chain_fetcher.sv
`timescale 1ns/1ps
module frame_chain_fetcher #(
  parameter int ADDR_W  = 32,
  parameter int BURST   = 16,
  parameter int DEPTH   = 2 * BURST,
  parameter int LEN_W   = 24,
  parameter int PAL_BIT = 28
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         start_wr,
  input  logic [ADDR_W-1:0]            start_addr,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [$clog2(BURST+1)-1:0]   mem_req_len,
  input  logic                         mem_rsp_valid,
  input  logic [31:0]                  mem_rsp_data,
  output logic                         pal_valid,
  input  logic                         pal_ready,
  output logic [15:0]                  pal_data,
  output logic                         pix_valid,
  input  logic                         pix_ready,
  output logic [31:0]                  pix_data,
  output logic                         frame_start,
  output logic [31:0]                  frame_id
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          buf_push, buf_pop, buf_empty, pal_mode;
  logic [31:0]   buf_head;
  logic [CW-1:0] buf_count;

  fcf_ctrl #(
    .ADDR_W(ADDR_W), .BURST(BURST), .DEPTH(DEPTH),
    .LEN_W(LEN_W), .PAL_BIT(PAL_BIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start_wr(start_wr), .start_addr(start_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .buf_push(buf_push), .buf_count(buf_count), .buf_empty(buf_empty),
    .pal_mode(pal_mode), .frame_start(frame_start), .frame_id(frame_id)
  );

  fcf_word_fifo #(.W(32), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(buf_push), .din(mem_rsp_data),
    .pop(buf_pop), .dout(buf_head),
    .empty(buf_empty), .count(buf_count)
  );

  fcf_route #(.W(32)) u_route (
    .clk(clk), .rst_n(rst_n),
    .head(buf_head), .head_vld(!buf_empty), .pal_mode(pal_mode),
    .pop(buf_pop),
    .pal_valid(pal_valid), .pal_ready(pal_ready), .pal_data(pal_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
  );
endmodule

// File: rtl/fcf_checker.sv
`timescale 1ns/1ps
module fcf_checker #(
  parameter int ADDR_W = 32,
  parameter int BURST  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mem_req_valid,
  input logic                       mem_req_ready,
  input logic [ADDR_W-1:0]          mem_req_addr,
  input logic [$clog2(BURST+1)-1:0] mem_req_len,
  input logic                       pal_valid,
  input logic                       pal_ready,
  input logic [15:0]                pal_data,
  input logic                       pix_valid,
  input logic                       pix_ready,
  input logic [31:0]                pix_data,
  input logic                       frame_start
);
  localparam int BL_W = $clog2(BURST + 1);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)));

  assert_req_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len != '0 && mem_req_len <= BL_W'(BURST)));

  assert_one_sink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pal_valid && pix_valid));

  assert_pal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_valid && !pal_ready) |=> (pal_valid && $stable(pal_data)));

  assert_pix_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  assert_fs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

bind frame_chain_fetcher fcf_checker #(.ADDR_W(ADDR_W), .BURST(BURST)) u_chk (.*);

// File: tb/frame_chain_fetcher_test.sv
`timescale 1ns/1ps
module frame_chain_fetcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        start_wr = 1'b0;
  logic [31:0] start_addr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [4:0]  mem_req_len;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        pal_valid;
  logic        pal_ready = 1'b0;
  logic [15:0] pal_data;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [31:0] pix_data;
  logic        frame_start;
  logic [31:0] frame_id;

  always #2.5 clk = ~clk;

  frame_chain_fetcher uut (.*);

  int nchecks = 0;
  int nerr = 0;
  int unsigned cyc = 0;

  logic [31:0] mem [0:4095];
  int unsigned rsp_q[$];
  int unsigned req_addr[$];
  int unsigned req_len[$];
  int unsigned req_dlv[$];
  int unsigned pal_log[$];
  int unsigned pix_log[$];
  int unsigned fs_log[$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] pat(input int unsigned i);
    return (i * 32'h0100_0193) ^ 32'hC3A5_0000;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // memory model and sinks, all acting away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = lfsr[0] | lfsr[1];
      pal_ready = lfsr[5] | lfsr[2];
      pix_ready = lfsr[7] | lfsr[4];
      if (mem_req_valid && mem_req_ready) begin
        req_addr.push_back(mem_req_addr);
        req_len.push_back(mem_req_len);
        req_dlv.push_back(pal_log.size() + pix_log.size());
      end
      if (rsp_q.size() > 0 && (lfsr[3] | lfsr[9])) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem[12'(rsp_q.pop_front())];
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (mem_req_valid && mem_req_ready)
        for (int i = 0; i < int'(mem_req_len); i++) rsp_q.push_back((mem_req_addr >> 2) + i);
      if (pal_valid && pal_ready) pal_log.push_back(pal_data);
      if (pix_valid && pix_ready) pix_log.push_back(pix_data);
      if (frame_start) fs_log.push_back(frame_id);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  task automatic clear_logs();
    req_addr.delete(); req_len.delete(); req_dlv.delete();
    pal_log.delete(); pix_log.delete(); fs_log.delete();
  endtask

  task automatic do_start(input logic [31:0] a);
    @(negedge clk); start_addr = a; start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
  endtask

  task automatic put_desc(input int unsigned base, input int unsigned link,
                          input int unsigned src, input int unsigned id,
                          input int unsigned cmd);
    mem[12'(base >> 2)]       = link;
    mem[12'((base >> 2) + 1)] = src;
    mem[12'((base >> 2) + 2)] = id;
    mem[12'((base >> 2) + 3)] = cmd;
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    while (quiet < 100) begin
      @(negedge clk);
      if (mem_req_valid || mem_rsp_valid || pal_valid || pix_valid || rsp_q.size() != 0)
        quiet = 0;
      else
        quiet++;
    end
  endtask

  task automatic t_reset();
    enable = 1'b1;
    repeat (30) @(negedge clk);
    check(req_addr.size() == 0, "R12", "requests before start", req_addr.size(), 0);
    check(!mem_req_valid, "R12", "mem_req_valid idle", mem_req_valid, 0);
    check(!pal_valid && !pix_valid, "R12", "outputs valid idle", {pal_valid, pix_valid}, 0);
    check(fs_log.size() == 0, "R12", "frame_start before start", fs_log.size(), 0);
  endtask

  task automatic t_single();
    int bad = 0;
    bit hit = 0;
    clear_logs();
    put_desc(32'h100, 32'h100, 32'h1000, 32'hA5, 37);
    enable = 1'b1;
    do_start(32'h100);
    for (int k = 0; k < 5000 && req_addr.size() < 1; k++) @(negedge clk);
    do_start(32'h200);   // strobe while active
    enable = 1'b0;
    wait_quiet();
    check(req_addr.size() == 4, "R8", "request count after stop", req_addr.size(), 4);
    if (req_addr.size() == 4) begin
      check(req_addr[0] == 32'h100 && req_len[0] == 4, "R1", "descriptor request", req_addr[0], 32'h100);
      check(req_addr[1] == 32'h1000 && req_len[1] == 16, "R3", "first burst", req_len[1], 16);
      check(req_addr[2] == 32'h1040 && req_len[2] == 16, "R2", "second burst address", req_addr[2], 32'h1040);
      check(req_addr[3] == 32'h1080 && req_len[3] == 5, "R3", "remainder burst", req_len[3], 5);
    end
    foreach (req_addr[i]) if (req_addr[i] == 32'h200) hit = 1;
    check(!hit, "R9", "request to ignored start address", hit, 0);
    check(pix_log.size() == 37, "R2", "pixel word count", pix_log.size(), 37);
    foreach (pix_log[i]) if (pix_log[i] != mem[12'((32'h1000 >> 2) + i)]) bad++;
    check(bad == 0, "R10", "pixel words in order", bad, 0);
    check(pal_log.size() == 0, "R4", "lookup entries for pixel payload", pal_log.size(), 0);
    check(fs_log.size() == 1 && fs_log[0] == 32'hA5, "R5", "frame_start id",
          fs_log.size() > 0 ? fs_log[0] : 0, 32'hA5);
  endtask

  task automatic t_restart();
    clear_logs();
    enable = 1'b1;
    repeat (60) @(negedge clk);
    check(req_addr.size() == 0, "R8", "no restart without strobe", req_addr.size(), 0);
  endtask

  task automatic t_zero_len();
    bit hit = 0;
    clear_logs();
    put_desc(32'h300, 32'h340, 32'h2000, 32'h11, 0);
    put_desc(32'h340, 32'h340, 32'h2400, 32'h22, 2);
    do_start(32'h300);
    for (int k = 0; k < 5000 && req_addr.size() < 2; k++) @(negedge clk);
    enable = 1'b0;
    wait_quiet();
    check(req_addr.size() == 3, "R11", "request count", req_addr.size(), 3);
    if (req_addr.size() == 3) begin
      check(req_addr[1] == 32'h340, "R11", "link followed after empty payload", req_addr[1], 32'h340);
      check(req_addr[2] == 32'h2400 && req_len[2] == 2, "R11", "payload of linked descriptor", req_addr[2], 32'h2400);
    end
    foreach (req_addr[i]) if (req_addr[i] == 32'h2000) hit = 1;
    check(!hit, "R11", "empty payload read", hit, 0);
    check(pix_log.size() == 2 && pix_log[0] == mem[12'(32'h2400 >> 2)],
          "R11", "pixel words", pix_log.size(), 2);
    check(fs_log.size() == 2 && fs_log[0] == 32'h11 && fs_log[1] == 32'h22,
          "R5", "frame ids", fs_log.size(), 2);
  endtask

  task automatic t_alternate();
    int unsigned ea [5] = '{32'h400, 32'h3000, 32'h440, 32'h3400, 32'h3440};
    int unsigned el [5] = '{4, 3, 4, 16, 5};
    int bad = 0, bad_dlv = 0, bad_pal = 0, bad_pix = 0, bad_fs = 0;
    int n = 0, nf = 0, np = 0, nfd = 0;
    clear_logs();
    put_desc(32'h400, 32'h440, 32'h3000, 32'h07, (1 << 28) | 3);
    put_desc(32'h440, 32'h400, 32'h3400, 32'h99, 21);
    enable = 1'b1;
    do_start(32'h400);
    for (int k = 0; k < 40000 && fs_log.size() < 3; k++) @(negedge clk);
    enable = 1'b0;
    wait_quiet();
    n = req_addr.size();
    foreach (req_addr[i]) begin
      if (req_addr[i] != ea[i % 5] || req_len[i] != el[i % 5]) bad++;
      if (i % 5 == 0 && req_dlv[i] != (i / 5) * 27) bad_dlv++;
      if (i % 5 == 2 && req_dlv[i] != (i / 5) * 27 + 6) bad_dlv++;
      if (i % 5 == 1) np++;
      if (i % 5 == 2) nfd++;
      if (i % 5 == 4) nf++;
    end
    check(n >= 10, "R7", "chain kept looping", n, 10);
    check(bad == 0, "R7", "request sequence mismatches", bad, 0);
    check(bad_dlv == 0, "R6", "descriptor fetched before payload drained", bad_dlv, 0);
    check(n % 5 == 0 || n % 5 == 2, "R8", "stopped on payload boundary", n % 5, 0);
    check(pal_log.size() == 6 * np, "R4", "lookup entry count", pal_log.size(), 6 * np);
    check(pix_log.size() == 21 * nf, "R10", "pixel word count", pix_log.size(), 21 * nf);
    foreach (pal_log[j]) begin
      logic [31:0] w;
      w = mem[12'((32'h3000 >> 2) + (j % 6) / 2)];
      if (pal_log[j] != ((j % 2) ? w[31:16] : w[15:0])) bad_pal++;
    end
    check(bad_pal == 0, "R4", "lookup halves low first", bad_pal, 0);
    foreach (pix_log[j]) if (pix_log[j] != mem[12'((32'h3400 >> 2) + (j % 21))]) bad_pix++;
    check(bad_pix == 0, "R10", "pixel words under back-pressure", bad_pix, 0);
    foreach (fs_log[j]) if (fs_log[j] != 32'h99) bad_fs++;
    check(bad_fs == 0 && fs_log.size() == nfd, "R5", "pulses only for frame descriptors",
          fs_log.size(), nfd);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_restart();
    t_zero_len();
    t_alternate();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule